// File: doc/BRIEF.md
# Eight-Channel PWM Generator with SPI Duty Programming

The block produces eight pulse-width-modulated outputs from one free-running 5-bit counter. Each channel has its own stored duty value. Every output goes high when the counter returns to zero and goes low once the count reaches that channel's duty. The counter and the compare logic run on a system clock of their own. The outputs therefore keep running at the last programmed duties after the host stops using the serial port.

A host programs a duty value with a two-byte SPI transfer in mode 0, MSB first. The first byte selects the channel and the second byte gives the duty. While the first byte is being shifted in, the block returns a snapshot of its eight general-purpose inputs on miso. The snapshot is taken when select falls.

A completed command crosses into the system clock domain by a toggle and a synchronizer, and is then held as a pending value. The pending value becomes active only at the next counter wrap, so no shortened or doubled pulse can appear.

Top module: `pwm8_spi_core`

## Requirements
- R1: A single counter shared by all channels steps by one on every clk edge from 0 to 31 and then wraps to 0, so every output has a period of 32 clk cycles whether or not the serial port is active.
- R2: While the counter value is 0, every output is high. At any other count n, channel i is high when n is less than its active duty and low otherwise. A duty of 0 gives one high cycle per period, and a duty of d between 1 and 31 gives d high cycles.
- R3: A command is 16 bits taken MSB first from mosi on rising sclk while cs_n is low. Bits [2:0] of the first byte select the channel and its upper five bits are ignored. The second byte is the duty value.
- R4: A received duty byte above 31 is stored as 31.
- R5: The value of a completed command is written to that channel's pending duty on the third clk rising edge after the 16th rising sclk edge. All pending duties become active on the clk edge on which the counter wraps from 31 to 0, and the active duties change on no other edge.
- R6: If cs_n rises before the 16th rising sclk edge, the transfer is discarded with no effect on any duty. The next transfer starts again at bit 0 of the first byte.
- R7: The gpin value is captured when cs_n falls. Its bit 7 is on miso while cs_n is low and before the first falling sclk edge. Each falling sclk edge then presents the next lower bit. After the 8th falling edge, and whenever cs_n is high, miso is 0.
- R8: While rst_n is low, all outputs are low and all duties are 0. The counter is held at 31, so the first clk edge after release takes it to 0 and drives every output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the counter and the outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low transfer select |
| gpin | input | 8 | General-purpose inputs returned to the host |
| miso | output | 1 | Serial data to the host |
| pwm_out | output | 8 | Pulse-width-modulated outputs |

## Verification
Each output is registered, so after every clk edge it shows the value for the count that edge produced. The bench model therefore applies its own step at the posedge and compares at the following negedge. The bench changes sclk only on clk falling edges. This makes the synchronizer delay exactly three clk edges from the 16th rising sclk edge to the pending write, and the model counts those same three edges down before applying the new duty at the next wrap. The miso bits are checked just before each rising sclk edge, which is a full half sclk period after the falling edge that changed them.

// File: rtl/pwm8_spi_core.sv
module pwm8_spi_core #(
  parameter int CHANNELS = 8,
  parameter int DUTY_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                mosi,
  input  logic                cs_n,
  input  logic [7:0]          gpin,
  output logic                miso,
  output logic [CHANNELS-1:0] pwm_out
);
  localparam int CH_W = $clog2(CHANNELS);
  localparam logic [DUTY_W-1:0] TOP = '1;

  // serial side
  logic [3:0]        bitcnt;
  logic [6:0]        sh;
  logic [CH_W-1:0]   cmd_ch, hold_ch;
  logic [DUTY_W-1:0] hold_duty;
  logic              tog;
  logic [7:0]        rx_byte, snap;
  logic [DUTY_W-1:0] rx_sat;
  logic [3:0]        fidx;

  assign rx_byte = {sh, mosi};
  assign rx_sat  = (|rx_byte[7:DUTY_W]) ? TOP : rx_byte[DUTY_W-1:0];

  always_ff @(posedge sclk or posedge cs_n or negedge rst_n)
    if (cs_n || !rst_n) begin
      bitcnt <= '0;
      sh     <= '0;
    end else begin
      bitcnt <= bitcnt + 4'd1;
      sh     <= rx_byte[6:0];
    end

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) begin
      cmd_ch    <= '0;
      hold_ch   <= '0;
      hold_duty <= '0;
      tog       <= 1'b0;
    end else begin
      if (bitcnt == 4'd7) cmd_ch <= rx_byte[CH_W-1:0];
      if (bitcnt == 4'd15) begin
        hold_ch   <= cmd_ch;
        hold_duty <= rx_sat;
        tog       <= ~tog;
      end
    end

  always_ff @(negedge cs_n or negedge rst_n)
    if (!rst_n) snap <= '0;
    else        snap <= gpin;

  always_ff @(negedge sclk or posedge cs_n or negedge rst_n)
    if (cs_n || !rst_n) fidx <= '0;
    else if (!fidx[3])  fidx <= fidx + 4'd1;

  assign miso = !cs_n && !fidx[3] && snap[~fidx[2:0]];

  // system clock side
  logic [2:0]        sync;
  logic              upd, wrap;
  logic [DUTY_W-1:0] cnt, cnt_n;
  logic [DUTY_W-1:0] pend [CHANNELS];
  logic [DUTY_W-1:0] act  [CHANNELS];

  assign upd   = sync[2] ^ sync[1];
  assign wrap  = (cnt == TOP);
  assign cnt_n = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync <= '0;
      cnt  <= TOP;
      for (int i = 0; i < CHANNELS; i++) begin
        pend[i] <= '0;
        act[i]  <= '0;
      end
    end else begin
      sync <= {sync[1:0], tog};
      cnt  <= cnt_n;
      if (upd) pend[hold_ch] <= hold_duty;
      if (wrap) for (int i = 0; i < CHANNELS; i++) act[i] <= pend[i];
    end

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [DUTY_W-1:0] act_n;
    assign act_n = wrap ? pend[g] : act[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pwm_out[g] <= 1'b0;
      else        pwm_out[g] <= (cnt_n == '0) || (cnt_n < act_n);

    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[g]) |-> (cnt == '0)); // R2
    AST_ACT_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act[g])); // R5
    AST_PEND_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(pend[g])); // R5
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == DUTY_W'($past(cnt) + 1'b1))); // R1
  AST_WRAP_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (&pwm_out)); // R2
endmodule

// File: tb/tb_pwm8_spi_core.sv
`timescale 1ns/1ps
module tb_pwm8_spi_core;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic [7:0] gpin = 8'h00;
  logic miso;
  logic [7:0] pwm_out;

  pwm8_spi_core dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
                     .cs_n(cs_n), .gpin(gpin), .miso(miso), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  task automatic chk(string tag, logic [31:0] actual, logic [31:0] expv);
    total++;
    if (actual !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expv, $time);
    end
  endtask

  // reference model
  int m_cnt = 31;
  int m_act [8];
  int m_pend[8];
  int q_ch[$], q_d[$], q_left[$];
  logic [7:0] m_exp = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 31;
      for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_pend[i] = 0; end
      m_exp = 8'h00;
    end else begin
      if (m_cnt == 31) for (int i = 0; i < 8; i++) m_act[i] = m_pend[i];
      for (int k = 0; k < q_left.size(); k++) q_left[k] = q_left[k] - 1;
      while (q_left.size() > 0 && q_left[0] <= 0) begin
        m_pend[q_ch[0]] = q_d[0];
        void'(q_ch.pop_front()); void'(q_d.pop_front()); void'(q_left.pop_front());
      end
      m_cnt = (m_cnt + 1) % 32;
      for (int i = 0; i < 8; i++) m_exp[i] = (m_cnt == 0) || (m_cnt < m_act[i]);
    end
  end

  always @(negedge clk) if (rst_n) chk(cur_req, pwm_out, m_exp);

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(logic [7:0] b0, logic [7:0] b1, int nbits);
    logic [15:0] word = {b0, b1};
    logic [7:0] g = gpin;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = word[15-i];
      wait_clk(2);
      if (i < 8) chk("R7", miso, g[7-i]);
      else       chk("R7", miso, 1'b0);
      sclk = 1'b1;
      if (i == 15) begin
        q_ch.push_back(int'(b0[2:0]));
        q_d.push_back((b1 > 8'd31) ? 31 : int'(b1));
        q_left.push_back(3);
      end
      wait_clk(2);
      sclk = 1'b0;
    end
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(2);
    chk("R7", miso, 1'b0);
  endtask

  initial begin
    wait_clk(3);
    chk("R8", pwm_out, 8'h00);
    chk("R8", miso, 1'b0);
    rst_n = 1'b1;
    cur_req = "R8";
    wait_clk(4);
    cur_req = "R1";
    wait_clk(70);

    cur_req = "R5"; gpin = 8'hA5;
    xfer(8'h03, 8'd10, 16);
    wait_clk(80);

    cur_req = "R2"; gpin = 8'h3C;
    xfer(8'h00, 8'd0, 16);
    xfer(8'h07, 8'd31, 16);
    wait_clk(70);

    cur_req = "R4"; gpin = 8'hFF;
    xfer(8'h05, 8'd200, 16);
    xfer(8'h01, 8'd32, 16);
    wait_clk(70);

    cur_req = "R3"; gpin = 8'h81;
    xfer(8'hFA, 8'd17, 16);
    wait_clk(70);

    cur_req = "R6"; gpin = 8'h5A;
    xfer(8'h03, 8'd25, 11);
    wait_clk(100);
    xfer(8'h04, 8'd1, 16);
    wait_clk(80);

    cur_req = "R1"; gpin = 8'h00;
    wait_clk(300);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule